// File: doc/BRIEF.md
# Edge-Tracking Bit Synchronizer with NRZI Decode

This block sits behind a tone slicer in a low-rate audio-FSK receiver. On each sample strobe it takes one sliced bit and keeps a short history of recent sliced bits. Whenever the two newest entries differ, it treats that as a transition and uses it to pull a phase accumulator toward the middle of the symbol. The accumulator advances by a fixed step on every strobe. When it passes the end of its range, the block decides one symbol by a two-out-of-three vote over the newest sliced bits.

Decided symbols are kept in a second small history, and the block undoes NRZI line coding on them. Two equal consecutive symbols give a data 1, and a change gives a data 0. Each decoded bit appears on `dout` together with a one-cycle `dout_vld` pulse. The next stage, frame delimiting and bit unstuffing, consumes the bit stream as it arrives.

Top module: `bitsync_nrzi`

## Requirements
- R1: While `rst_n` is low, the phase accumulator, the sliced-bit history and the symbol history are cleared to zero, and `dout` and `dout_vld` are 0. The first symbol decided after reset is therefore compared against a previous symbol of 0.
- R2: State changes only on a rising clock edge where `smp_stb` is 1. With `smp_stb` at 0, `smp_bit` is ignored and no bit is produced.
- R3: A transition is present on a strobe when the incoming `smp_bit` differs from the sliced bit of the previous strobe. On a transition, the phase first moves up by 1 if it is below 32 and otherwise moves down by 1.
- R4: After any transition adjustment, every strobe adds 8 to the phase. When the result is 64 or more, 64 is subtracted and one symbol is decided. From reset, with no transitions, the first decision falls on the 8th strobe and every 8th strobe after that.
- R5: A decided symbol is 1 when at least two of the three newest sliced bits, counting the current `smp_bit`, are 1. Otherwise it is 0.
- R6: `dout` is 1 when the newly decided symbol equals the previously decided symbol, and 0 when they differ.
- R7: `dout_vld` is high for exactly the one clock cycle after each deciding strobe. `dout` is updated in that same cycle and holds its value at all other times.
- R8: The phase accumulator always stays in the range 0 to 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_stb | input | 1 | Sample strobe; one sliced bit is taken on each high cycle |
| smp_bit | input | 1 | Sliced tone bit (1 = mark side of the slicer) |
| dout | output | 1 | NRZI-decoded data bit |
| dout_vld | output | 1 | One-cycle pulse marking a new `dout` |

## Verification
A constant input has no transitions. It shows that decisions come at the bare 8-strobe cadence, and it exposes the first comparison against the cleared symbol history. Strobe-free stretches with a toggling `smp_bit` separate a correct strobe gate from one that samples every clock. Symbol streams of 7, 8 and 9 samples per symbol drive the accumulator both up and down, so an error in the direction or the ordering of the nudge shows up as a shifted decision cycle. Single-sample glitches near the decision point test the vote, NRZI-coded data tests the equality rule, and a long pseudo-random stream with gapped strobes covers the remaining phase values.

// File: rtl/bs_pkg.sv
package bs_pkg;

  // Phase after the optional transition nudge and the per-strobe advance,
  // before any wrap is applied.
  function automatic int phase_adv(int ph, logic edg, int mid, int step, int nudge);
    int t;
    t = ph;
    if (edg) begin
      if (ph < mid) t = ph + nudge;
      else          t = ph - nudge;
    end
    return t + step;
  endfunction

  // Reduce an advanced phase back into range.
  function automatic int phase_wrap(int sum, int pmax);
    return (sum >= pmax) ? (sum % pmax) : sum;
  endfunction

  // Majority over the low n bits of v.
  function automatic logic maj_vote(logic [31:0] v, int n);
    int cnt;
    cnt = 0;
    for (int i = 0; i < 32; i++) begin
      if (i < n) cnt += int'(v[i]);
    end
    return (2 * cnt > n);
  endfunction

endpackage

// File: rtl/bs_sample_hist.sv
module bs_sample_hist #(
  parameter int HIST_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_i,
  input  logic              bit_i,
  output logic [HIST_W-1:0] hist_now_o,
  output logic              edge_o
);
  logic [HIST_W-1:0] hist_q;

  // History as seen with the current sample already shifted in.
  assign hist_now_o = {hist_q[HIST_W-2:0], bit_i};
  assign edge_o     = hist_now_o[1] ^ hist_now_o[0];

  always_ff @(posedge clk) begin
    if (!rst_n)     hist_q <= '0;
    else if (stb_i) hist_q <= hist_now_o;
  end
endmodule

// File: rtl/bs_phase_trk.sv
module bs_phase_trk #(
  parameter int PH_MAX = 64,
  parameter int PH_MID = 32,
  parameter int STEP   = 8,
  parameter int NUDGE  = 1,
  parameter int PH_W   = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stb_i,
  input  logic            edge_i,
  output logic [PH_W-1:0] phase_o,
  output logic            wrap_o
);
  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] phase_d;
  int              sum;

  always_comb begin
    sum     = bs_pkg::phase_adv(int'(phase_q), edge_i, PH_MID, STEP, NUDGE);
    wrap_o  = stb_i && (sum >= PH_MAX);
    phase_d = PH_W'(bs_pkg::phase_wrap(sum, PH_MAX));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     phase_q <= '0;
    else if (stb_i) phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/bs_sym_decide.sv
module bs_sym_decide #(
  parameter int VOTE_N = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [VOTE_N-1:0] votes_i,
  output logic              sym_o,
  output logic              dout_o,
  output logic              vld_o
);
  logic sym;
  logic prev_q;

  assign sym   = bs_pkg::maj_vote(32'(votes_i), VOTE_N);
  assign sym_o = sym;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      dout_o <= 1'b0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= take_i;
      if (take_i) begin
        prev_q <= sym;
        dout_o <= (sym == prev_q);
      end
    end
  end
endmodule

// File: rtl/bitsync_nrzi.sv
module bitsync_nrzi #(
  parameter int SPB    = 8,
  parameter int STEP   = 8,
  parameter int NUDGE  = 1,
  parameter int VOTE_N = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_stb,
  input  logic smp_bit,
  output logic dout,
  output logic dout_vld
);
  localparam int PH_MAX = SPB * STEP;
  localparam int PH_MID = PH_MAX / 2;
  localparam int PH_W   = $clog2(PH_MAX + STEP + NUDGE + 1);
  localparam int HIST_W = (VOTE_N < 2) ? 2 : VOTE_N;

  // Named internal events, brought out for the checker.
  logic [HIST_W-1:0] hist_now;
  logic              edge_w;
  logic              wrap_w;
  logic [PH_W-1:0]   phase_q;
  logic              sym_w;

  bs_sample_hist #(.HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .stb_i(smp_stb), .bit_i(smp_bit),
    .hist_now_o(hist_now), .edge_o(edge_w)
  );

  bs_phase_trk #(
    .PH_MAX(PH_MAX), .PH_MID(PH_MID), .STEP(STEP), .NUDGE(NUDGE), .PH_W(PH_W)
  ) u_phase (
    .clk(clk), .rst_n(rst_n), .stb_i(smp_stb), .edge_i(edge_w),
    .phase_o(phase_q), .wrap_o(wrap_w)
  );

  bs_sym_decide #(.VOTE_N(VOTE_N)) u_sym (
    .clk(clk), .rst_n(rst_n), .take_i(wrap_w),
    .votes_i(hist_now[VOTE_N-1:0]),
    .sym_o(sym_w), .dout_o(dout), .vld_o(dout_vld)
  );
endmodule

// File: rtl/bitsync_nrzi_chk.sv
module bitsync_nrzi_chk #(
  parameter int PH_W   = 7,
  parameter int PH_MAX = 64,
  parameter int PH_MID = 32,
  parameter int STEP   = 8,
  parameter int NUDGE  = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            smp_stb,
  input logic            edge_w,
  input logic            wrap_w,
  input logic [PH_W-1:0] phase_q,
  input logic            dout,
  input logic            dout_vld
);
  AST_IDLE_HOLDS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> $stable(phase_q)); // R2

  AST_NUDGE_UP: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb && edge_w && (int'(phase_q) < PH_MID) && !wrap_w
    |=> int'(phase_q) == int'($past(phase_q)) + STEP + NUDGE); // R3

  AST_NUDGE_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb && edge_w && (int'(phase_q) >= PH_MID) && !wrap_w
    |=> int'(phase_q) == int'($past(phase_q)) + STEP - NUDGE); // R3

  AST_PLAIN_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb && !edge_w && !wrap_w
    |=> int'(phase_q) == int'($past(phase_q)) + STEP); // R4

  AST_WRAP_GIVES_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb && wrap_w |=> dout_vld); // R4

  AST_VLD_NEEDS_STB: assert property (@(posedge clk) disable iff (!rst_n)
    dout_vld |-> $past(smp_stb)); // R7

  AST_DOUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_vld |-> $stable(dout)); // R7

  AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(phase_q) < PH_MAX); // R8
endmodule

bind bitsync_nrzi bitsync_nrzi_chk #(
  .PH_W(PH_W), .PH_MAX(PH_MAX), .PH_MID(PH_MID), .STEP(STEP), .NUDGE(NUDGE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .edge_w(edge_w),
  .wrap_w(wrap_w), .phase_q(phase_q), .dout(dout), .dout_vld(dout_vld)
);

// File: tb/sim_bitsync_nrzi.sv
`timescale 1ns/1ps
module sim_bitsync_nrzi;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_stb = 1'b0;
  logic smp_bit = 1'b0;
  logic dout, dout_vld;

  always #2.5 clk = ~clk;

  bitsync_nrzi u0 (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_bit(smp_bit),
    .dout(dout), .dout_vld(dout_vld)
  );

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;
  string cur_req = "R1";

  // Behavioural reference model.
  bit samp_q[$];
  int m_ph;
  bit m_prev_sym;
  bit exp_dout, exp_vld;
  int vld_seen;
  int lfsr = 32'h1d2c3b4a;

  function automatic void model_reset();
    samp_q = '{1'b0, 1'b0, 1'b0};
    m_ph = 0;
    m_prev_sym = 1'b0;
    exp_dout = 1'b0;
    exp_vld = 1'b0;
  endfunction

  function automatic void model_step(bit stb, bit b);
    int ones;
    bit sym;
    exp_vld = 1'b0;
    if (!stb) return;
    samp_q.push_back(b);
    void'(samp_q.pop_front());
    if (samp_q[2] != samp_q[1]) begin
      if (m_ph < 32) m_ph = m_ph + 1;
      else           m_ph = m_ph - 1;
    end
    m_ph = m_ph + 8;
    if (m_ph >= 64) begin
      m_ph = m_ph % 64;
      ones = 0;
      foreach (samp_q[i]) ones += int'(samp_q[i]);
      sym = (ones >= 2);
      exp_dout = (sym == m_prev_sym);
      m_prev_sym = sym;
      exp_vld = 1'b1;
    end
  endfunction

  task automatic check(bit ok, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s (%s): actual %0d expected %0d at %0t", what, cur_req, act, exp, $time);
    end
  endtask

  // One clock: drive at the falling edge, model at the rising edge,
  // compare at the next falling edge.
  task automatic cyc(bit stb, bit b);
    smp_stb = stb;
    smp_bit = b;
    @(posedge clk);
    if (rst_n) model_step(stb, b);
    @(negedge clk);
    check(dout_vld == exp_vld, "R7 dout_vld", int'(dout_vld), int'(exp_vld));
    check(dout == exp_dout, "R6 dout", int'(dout), int'(exp_dout));
    if (dout_vld) vld_seen++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    smp_stb = 1'b0;
    repeat (3) @(negedge clk);
    model_reset();
    cur_req = "R1";
    check(dout == 1'b0, "R1 dout in reset", int'(dout), 0);
    check(dout_vld == 1'b0, "R1 dout_vld in reset", int'(dout_vld), 0);
    rst_n = 1'b1;
  endtask

  task automatic send_sym(bit v, int len, bit gapped);
    for (int k = 0; k < len; k++) begin
      cyc(1'b1, v);
      if (gapped) cyc(1'b0, ~v);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit line;
    @(negedge clk);
    do_reset();

    // R4: constant 1, no transitions, decisions every 8 strobes.
    cur_req = "R4";
    vld_seen = 0;
    for (int k = 0; k < 7; k++) cyc(1'b1, 1'b1);
    check(vld_seen == 0, "R4 no decision before 8th strobe", vld_seen, 0);
    cyc(1'b1, 1'b1);
    check(dout_vld == 1'b1, "R4 decision on 8th strobe", int'(dout_vld), 1);
    cur_req = "R1";
    check(dout == 1'b0, "R1 first symbol 1 vs cleared 0", int'(dout), 0);
    cur_req = "R4";
    for (int k = 0; k < 16; k++) cyc(1'b1, 1'b1);
    check(vld_seen == 3, "R4 three decisions in 24 strobes", vld_seen, 3);

    // R2: no strobe, toggling bit: ignored.
    cur_req = "R2";
    vld_seen = 0;
    for (int k = 0; k < 21; k++) cyc(1'b0, k[0]);
    check(vld_seen == 0, "R2 no output without strobe", vld_seen, 0);
    for (int k = 0; k < 8; k++) cyc(1'b1, 1'b1);
    check(vld_seen == 1, "R2 cadence unchanged by idle input", vld_seen, 1);
    check(dout == 1'b1, "R2 symbol unchanged by idle input", int'(dout), 1);

    // R1/R6: first decision after reset with constant 0 equals cleared symbol.
    do_reset();
    cur_req = "R6";
    for (int k = 0; k < 8; k++) cyc(1'b1, 1'b0);
    check(dout == 1'b1, "R6 first symbol 0 vs cleared 0", int'(dout), 1);

    // R3: symbols of uneven length force nudges both ways.
    cur_req = "R3";
    line = 1'b0;
    for (int k = 0; k < 40; k++) begin
      line = ~line;
      send_sym(line, (k % 3 == 0) ? 7 : ((k % 3 == 1) ? 9 : 8), 1'b0);
    end

    // R5: single-sample glitches inside long symbols.
    cur_req = "R5";
    for (int k = 0; k < 24; k++) begin
      for (int j = 0; j < 8; j++) cyc(1'b1, (j == (k % 8)) ? ~line : line);
      if (k % 4 == 3) line = ~line;
    end

    // R6: NRZI-coded data, 0 toggles the line, 1 keeps it.
    cur_req = "R6";
    for (int k = 0; k < 48; k++) begin
      lfsr = (lfsr << 1) ^ ((lfsr < 0) ? 32'h04c11db7 : 0);
      if (!lfsr[3]) line = ~line;
      send_sym(line, 8, k[2]);
    end

    // R8: pseudo-random sliced stream with random strobe gaps.
    cur_req = "R8";
    for (int k = 0; k < 3000; k++) begin
      lfsr = (lfsr << 1) ^ ((lfsr < 0) ? 32'h04c11db7 : 0);
      if (lfsr[5:4] == 2'b00) line = ~line;
      cyc(lfsr[7:6] != 2'b00, lfsr[9:8] == 2'b11 ? ~line : line);
    end

    // R1: reset in mid-stream clears everything.
    do_reset();
    cur_req = "R7";
    vld_seen = 0;
    for (int k = 0; k < 16; k++) cyc(1'b1, 1'b1);
    check(vld_seen == 2, "R7 pulses after mid-stream reset", vld_seen, 2);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule